// File: doc/BRIEF.md
# Ingress Relaxed-Ordering Packet Scheduler

This block sits behind one ingress port of a packet switch. It keeps up to sixteen packet descriptors in arrival order. Each cycle it forwards at most one of them towards the egress side. A descriptor names a traffic class, a destination egress port, whether it is non-posted, and an opaque tag. Every egress port has its own ready line. A descriptor can leave only when its egress port is ready and no older descriptor holds it back.

An eight-bit enable, one bit per traffic class, selects how strict ordering is. With a class bit clear, the class leaves in strict arrival order. A stalled egress port then holds back every younger packet of that class. With the bit set, a posted packet of the class may overtake older posted packets of the same class that go to a different egress port. Packets bound for the same egress port always keep their order. Non-posted packets act as barriers inside their class. Classes never block one another.

The enable is loaded from a 32-bit configuration word shared by four ports. Each port takes one byte lane, chosen by its port number modulo four. Among all eligible descriptors the oldest one is issued. The queue closes the gap left behind, so that age order is kept.

Top module: `ro_pkt_sched`

## Requirements
- R1: After reset the queue is empty, `out_valid` is 0, `in_ready` is 1 and `cfg_en` reads 0, so every class starts in strict mode.
- R2: A cycle with `cfg_we` high loads `cfg_wdata[8*L+7:8*L]` into `cfg_en`, where L = PORT_ID mod 4 and bit k of `cfg_en` enables relaxed mode for class k. The other three bytes of `cfg_wdata` have no effect.
- R3: A descriptor is taken when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is low exactly while 16 descriptors are held, and an offer made while it is low is lost.
- R4: While the enable bit of a class is 0, descriptors of that class leave in arrival order, even when they target different egress ports.
- R5: While the enable bit of a class is 1, a posted descriptor may leave before older posted descriptors of the same class that target a different egress port.
- R6: Descriptors of one class that target the same egress port leave in arrival order, whatever the enable bit says.
- R7: A non-posted descriptor (`in_np`=1) neither passes nor is passed by any older or younger descriptor of its own class.
- R8: A descriptor is never held back by older descriptors of a different traffic class.
- R9: A descriptor leaves only if `eg_ready[eg]` was high in the selection cycle. At most one descriptor leaves per cycle, and it is the oldest eligible one.
- R10: The descriptor chosen at a rising edge is shown on the `out_*` ports with `out_valid`=1 for the following cycle. An enable write at edge t first affects the selection at edge t+1.
- R11: When descriptors are removed from the middle of the queue, or one is taken and one issued in the same cycle, the remaining descriptors keep their relative age order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Queue can take a descriptor |
| in_tc | input | 3 | Traffic class of the offered descriptor |
| in_eg | input | 3 | Destination egress port |
| in_np | input | 1 | 1 = non-posted, 0 = posted |
| in_tag | input | 8 | Opaque tag carried through |
| eg_ready | input | 8 | Per-egress-port ready |
| out_valid | output | 1 | Issued descriptor valid this cycle |
| out_tc | output | 3 | Traffic class of the issued descriptor |
| out_eg | output | 3 | Egress port of the issued descriptor |
| out_np | output | 1 | Type of the issued descriptor |
| out_tag | output | 8 | Tag of the issued descriptor |
| cfg_we | input | 1 | Write strobe for the shared enable word |
| cfg_wdata | input | 32 | Shared enable word, one byte per port lane |
| cfg_en | output | 8 | Current per-class relaxed enable |

## Verification
Taking in a new descriptor and issuing an old one can happen in the same edge. The queue must then shift and append together, and the append goes one slot lower. The bench provokes this by streaming twenty descriptors back to back while every egress port is ready. It also fills the queue and then drains it, and it judges both runs by the exact order of the tags and by one issue per cycle. An enable write can also meet a pending selection in the same edge. The bench writes the enable bit while an overtaking candidate waits, and checks that the candidate leaves in the second cycle after the write and not in the first.

// File: rtl/ro_sched_pkg.sv
package ro_sched_pkg;
    localparam int TC_W   = 3;
    localparam int NUM_TC = 1 << TC_W;
    localparam int EG_W   = 3;
    localparam int NUM_EG = 1 << EG_W;
    localparam int TAG_W  = 8;
    localparam int CFG_W  = 32;
    localparam int LANES  = CFG_W / NUM_TC;

    typedef struct packed {
        logic [TC_W-1:0]  tc;
        logic [EG_W-1:0]  eg;
        logic             np;
        logic [TAG_W-1:0] tag;
    } desc_t;
endpackage

// File: rtl/ro_en_reg.sv
module ro_en_reg
    import ro_sched_pkg::*;
#(
    parameter int PORT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [NUM_TC-1:0] en
);
    localparam int LANE = PORT_ID % LANES;

    logic [NUM_TC-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (cfg_we) begin
            en_d = cfg_wdata[LANE*NUM_TC +: NUM_TC];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en = en_q;

    // R2: the own byte lane is taken on a write
    p_lane_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> en_q == $past(cfg_wdata[LANE*NUM_TC +: NUM_TC]));

    // R2: the enable holds without a write
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(en_q));
endmodule

// File: rtl/ro_queue.sv
module ro_queue
    import ro_sched_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  desc_t                     push_desc,
    input  logic                      pop,
    input  logic [$clog2(DEPTH)-1:0]  pop_idx,
    output desc_t [DEPTH-1:0]         ents,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        desc_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]  cnt;
    } q_st_t;

    q_st_t st_d, st_q;
    logic [CNT_W-1:0] wr_pos;

    always_comb begin
        st_d   = st_q;
        wr_pos = st_q.cnt - CNT_W'(pop);
        // close the gap left by the issued entry
        for (int i = 0; i < DEPTH-1; i++) begin
            if (pop && (IDX_W'(i) >= pop_idx)) begin
                st_d.ent[i] = st_q.ent[i+1];
            end
        end
        // append behind the youngest remaining entry
        for (int i = 0; i < DEPTH; i++) begin
            if (push && (CNT_W'(i) == wr_pos)) begin
                st_d.ent[i] = push_desc;
            end
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ents = st_q.ent;
    assign cnt  = st_q.cnt;

    // R3: occupancy never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R3: an accepted descriptor without an issue grows the queue by one
    p_push_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> st_q.cnt == $past(st_q.cnt) + CNT_W'(1));

    // R11: an issue without an accept shrinks the queue by one
    p_pop_shrink_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> st_q.cnt == $past(st_q.cnt) - CNT_W'(1));

    // R11: simultaneous accept and issue leaves occupancy unchanged
    p_swap_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push) |=> $stable(st_q.cnt));

    // R9: only a held entry is ever issued
    p_pop_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> CNT_W'(pop_idx) < st_q.cnt);
endmodule

// File: rtl/ro_elig.sv
module ro_elig
    import ro_sched_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  desc_t [DEPTH-1:0]          ents,
    input  logic [$clog2(DEPTH+1)-1:0] cnt,
    input  logic [NUM_TC-1:0]          en,
    input  logic [NUM_EG-1:0]          eg_ready,
    output logic [DEPTH-1:0]           elig
);
    localparam int CNT_W = $clog2(DEPTH+1);

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        logic blocked;
        logic held;

        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < gi; j++) begin
                if (ents[j].tc == ents[gi].tc) begin
                    if (!en[ents[gi].tc] ||
                        (ents[j].eg == ents[gi].eg) ||
                        ents[j].np || ents[gi].np) begin
                        blocked = 1'b1;
                    end
                end
            end
        end

        assign held     = CNT_W'(gi) < cnt;
        assign elig[gi] = held && eg_ready[ents[gi].eg] && !blocked;
    end
endmodule

// File: rtl/ro_pick.sv
module ro_pick #(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0]         elig,
    output logic                     found,
    output logic [$clog2(DEPTH)-1:0] idx
);
    localparam int IDX_W = $clog2(DEPTH);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ro_pkt_sched.sv
module ro_pkt_sched
    import ro_sched_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int PORT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TC_W-1:0]   in_tc,
    input  logic [EG_W-1:0]   in_eg,
    input  logic              in_np,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [NUM_EG-1:0] eg_ready,
    output logic              out_valid,
    output logic [TC_W-1:0]   out_tc,
    output logic [EG_W-1:0]   out_eg,
    output logic              out_np,
    output logic [TAG_W-1:0]  out_tag,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [NUM_TC-1:0] cfg_en
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic  vld;
        desc_t d;
    } ost_t;

    desc_t [DEPTH-1:0] ents;
    logic [CNT_W-1:0]  cnt;
    logic [DEPTH-1:0]  elig;
    logic              found;
    logic [IDX_W-1:0]  pick_idx;
    logic [NUM_TC-1:0] en;
    logic              push;
    desc_t             in_desc;
    ost_t              o_d, o_q;

    assign in_ready = cnt < CNT_W'(DEPTH);
    assign push     = in_valid && in_ready;
    assign in_desc  = '{tc: in_tc, eg: in_eg, np: in_np, tag: in_tag};

    ro_en_reg #(.PORT_ID(PORT_ID)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .en        (en)
    );

    ro_queue #(.DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_desc (in_desc),
        .pop       (found),
        .pop_idx   (pick_idx),
        .ents      (ents),
        .cnt       (cnt)
    );

    ro_elig #(.DEPTH(DEPTH)) u_elig (
        .ents     (ents),
        .cnt      (cnt),
        .en       (en),
        .eg_ready (eg_ready),
        .elig     (elig)
    );

    ro_pick #(.DEPTH(DEPTH)) u_pick (
        .elig  (elig),
        .found (found),
        .idx   (pick_idx)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = found;
        if (found) begin
            o_d.d = ents[pick_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_tc    = o_q.d.tc;
    assign out_eg    = o_q.d.eg;
    assign out_np    = o_q.d.np;
    assign out_tag   = o_q.d.tag;
    assign cfg_en    = en;

    // ---------------- assertions ----------------
    logic [NUM_EG-1:0] rdy_seen_q;
    logic              older_tc;
    logic              older_tc_eg;

    always_ff @(posedge clk) begin
        rdy_seen_q <= eg_ready;
    end

    always_comb begin
        older_tc    = 1'b0;
        older_tc_eg = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if ((IDX_W'(j) < pick_idx) && (ents[j].tc == ents[pick_idx].tc)) begin
                older_tc = 1'b1;
                if (ents[j].eg == ents[pick_idx].eg) older_tc_eg = 1'b1;
            end
        end
    end

    // R9: issued descriptor had its egress ready in the selection cycle
    p_egress_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> rdy_seen_q[out_eg]);

    // R9: no eligible entry is older than the one picked
    p_oldest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (elig & ((DEPTH'(1) << pick_idx) - DEPTH'(1))) == '0);

    // R9: an issue needs a non-empty queue in the previous cycle
    p_issue_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(cnt) != '0);

    // R4: strict class never overtakes an older same-class entry
    p_strict_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !en[ents[pick_idx].tc]) |-> !older_tc);

    // R6: same class and same egress never overtaken
    p_same_egress_r6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !older_tc_eg);

    // R7: a non-posted entry never passes its class
    p_np_barrier_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (found && ents[pick_idx].np) |-> !older_tc);

    // R10: issue strobe lasts one cycle per selection
    p_out_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> out_valid);
endmodule

// File: tb/sim_ro_pkt_sched.sv
module sim_ro_pkt_sched;
    import ro_sched_pkg::*;

    localparam int DEPTH   = 16;
    localparam int PORT_ID = 9;
    localparam int LANE    = PORT_ID % 4;
    localparam int WD      = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [TC_W-1:0]   in_tc = '0;
    logic [EG_W-1:0]   in_eg = '0;
    logic              in_np = 1'b0;
    logic [TAG_W-1:0]  in_tag = '0;
    logic [NUM_EG-1:0] eg_ready = '0;
    logic              out_valid;
    logic [TC_W-1:0]   out_tc;
    logic [EG_W-1:0]   out_eg;
    logic              out_np;
    logic [TAG_W-1:0]  out_tag;
    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [NUM_TC-1:0] cfg_en;

    int vectors = 0;
    int errs    = 0;
    int cyc     = 0;
    int log_n   = 0;
    int log_tag [64];
    int log_cyc [64];
    bit done    = 0;

    ro_pkt_sched #(.DEPTH(DEPTH), .PORT_ID(PORT_ID)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_tc(in_tc), .in_eg(in_eg), .in_np(in_np), .in_tag(in_tag),
        .eg_ready(eg_ready),
        .out_valid(out_valid), .out_tc(out_tc), .out_eg(out_eg),
        .out_np(out_np), .out_tag(out_tag),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_en(cfg_en)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // output monitor, 5 ns after the rising edge
    always begin
        @(posedge clk);
        #5;
        if (rst_n && out_valid) begin
            if (log_n < 64) begin
                log_tag[log_n] = int'(out_tag);
                log_cyc[log_n] = cyc;
            end
            log_n++;
        end
    end

    always @(posedge clk) begin
        if (cyc == WD && !done) begin
            errs++;
            $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, WD);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; cfg_we = 1'b0; eg_ready = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic cfg_write(input logic [7:0] b, input logic [31:0] others);
        cfg_wdata = others;
        cfg_wdata[LANE*8 +: 8] = b;
        cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic push(input int tc, input int eg, input int np, input int tag);
        in_valid = 1'b1;
        in_tc    = TC_W'(tc);
        in_eg    = EG_W'(eg);
        in_np    = np[0];
        in_tag   = TAG_W'(tag);
        tick(1);
        in_valid = 1'b0;
    endtask

    initial begin
        // ---- reset state R1 ----
        do_reset();
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "in_ready after reset", int'(in_ready), 1);
        chk("R1", "cfg_en after reset", int'(cfg_en), 0);

        // ---- pairwise sweep: older A stalled on egress 0, younger B ----
        for (int tca = 0; tca < 2; tca++)
        for (int tcb = 0; tcb < 2; tcb++)
        for (int egb = 0; egb < 2; egb++)
        for (int npa = 0; npa < 2; npa++)
        for (int npb = 0; npb < 2; npb++)
        for (int ena = 0; ena < 2; ena++) begin
            logic [7:0] enb;
            bit early;
            string req;
            enb = (ena != 0) ? 8'(1 << tcb) : ~8'(1 << tcb);
            early = (egb == 1) && ((tca != tcb) || (ena != 0 && npa == 0 && npb == 0));
            if (egb == 0)            req = "R6";
            else if (tca != tcb)     req = "R8";
            else if (npa || npb)     req = "R7";
            else if (ena != 0)       req = "R5";
            else                     req = "R4";

            do_reset();
            cfg_write(enb, {4{~enb}});
            chk("R2", "cfg_en lane load", int'(cfg_en), int'(enb));
            eg_ready = '0;
            push(tca, 0, npa, 1);
            push(tcb, egb, npb, 2);
            log_n = 0;
            eg_ready = 8'h02;
            tick(4);
            chk(req, "overtake count", log_n, early ? 1 : 0);
            eg_ready = 8'hFF;
            tick(4);
            chk("R9", "total issued", log_n, 2);
            chk(req, "first tag", log_tag[0], early ? 2 : 1);
            chk(req, "second tag", log_tag[1], early ? 1 : 2);
        end

        // ---- fill to full, refuse extra, drain in order R3 R9 R11 ----
        do_reset();
        eg_ready = '0;
        for (int k = 0; k < DEPTH; k++) begin
            chk("R3", "in_ready while filling", int'(in_ready), 1);
            push(k % 8, k % 8, 0, k);
        end
        chk("R3", "in_ready when full", int'(in_ready), 0);
        push(1, 1, 0, 99);
        log_n = 0;
        eg_ready = 8'hFF;
        tick(DEPTH + 4);
        chk("R3", "drained count", log_n, DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R11", "drain order", log_tag[k], k);
            chk("R9", "one per cycle", log_cyc[k] - log_cyc[0], k);
        end
        chk("R1", "in_ready after drain", int'(in_ready), 1);

        // ---- stream with accept and issue in the same edge R11 ----
        do_reset();
        eg_ready = 8'hFF;
        log_n = 0;
        for (int k = 0; k < 20; k++) begin
            chk("R3", "in_ready while streaming", int'(in_ready), 1);
            push(k % 2, k % 8, k % 3 == 0 ? 1 : 0, 32 + k);
        end
        tick(4);
        chk("R11", "stream count", log_n, 20);
        for (int k = 0; k < 20; k++) begin
            chk("R11", "stream order", log_tag[k], 32 + k);
        end

        // ---- enable write timing R10 ----
        do_reset();
        cfg_write(8'h00, 32'h0);
        eg_ready = '0;
        push(3, 0, 0, 7);
        push(3, 1, 0, 8);
        log_n = 0;
        eg_ready = 8'h02;
        tick(3);
        chk("R4", "strict hold", log_n, 0);
        cfg_wdata = '0;
        cfg_wdata[LANE*8 +: 8] = 8'h08;
        cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
        chk("R10", "no issue at load edge", int'(out_valid), 0);
        chk("R2", "cfg_en after write", int'(cfg_en), 8'h08);
        tick(1);
        chk("R10", "issue next edge", int'(out_valid), 1);
        chk("R10", "issued tag", int'(out_tag), 8);
        chk("R10", "issued egress", int'(out_eg), 1);
        chk("R10", "issued class", int'(out_tc), 3);
        tick(1);
        chk("R10", "strobe one cycle", int'(out_valid), 0);
        chk("R9", "stalled head stays", log_n, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule